// File: doc/BRIEF.md
# Vertical Chroma Line-Rate Converter

This block raises the vertical line rate of a two's-complement chroma stream by four output lines for every three input lines. Each output line is computed inside one field by a polyphase filter. U and V run through identical datapaths. Samples arrive as 2-bit slices, four per 8-bit sample. A field strobe and a line strobe frame the stream. Upstream delivers one line of slices during every output line period. A two-bit phase counter decides whether that line is kept as filter history or thrown away.

With interpolation enabled, each output sample is a weighted sum of the newest stored lines at the same column. Camera mode uses three stored lines and film mode uses four, each with its own per-phase coefficient set (7 fractional bits). The sum is rounded and clamped to the signed 8-bit range. With interpolation disabled, the reassembled input sample is copied to the output unchanged.

Top module: `vcc_chroma_vsrc`

## Requirements
- R1: A sample is four consecutive slices with `in_vld` high, taken most significant first. The first slice is bits 7:6 and the last is bits 1:0, for U and for V.
- R2: When `interp_en` is 0, the output equals the reassembled input sample, whatever `film_sel` is.
- R3: A field strobe sets the phase to 0. Each line strobe without a field strobe advances the phase modulo 4, in every mode.
- R4: At a line strobe that ends a phase-0, 1 or 2 line, the line just received becomes history line 0 and older lines move down one place. At a line strobe that ends a phase-3 line, the received line is discarded.
- R5: In camera mode (`interp_en`=1, `film_sel`=0), history taps 0 to 2 (newest first) are weighted per phase as follows: phase 0 {64,64,0}, phase 1 {32,80,16}, phase 2 {16,80,32}, phase 3 {0,64,64}.
- R6: In film mode (`interp_en`=1, `film_sel`=1), history taps 0 to 3 are weighted per phase as follows: phase 0 {-8,72,72,-8}, phase 1 {-4,48,96,-12}, phase 2 {-12,96,48,-4}, phase 3 {0,128,0,0}.
- R7: The weighted sum is rounded as floor((sum+64)/128), then clamped to the range -128..127.
- R8: A field strobe empties the history. A tap with no line yet stored in the current field contributes 0, so the first line of a field gives 0 (blanking).
- R9: Only the first `LINE_SAMPLES` samples of a line produce outputs or are stored. Later samples in that line are ignored.
- R10: `out_vld` pulses exactly once per accepted sample, in the cycle after its fourth slice. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_strb | input | 1 | Start of field; one-cycle pulse |
| ln_strb | input | 1 | Start of output line; one-cycle pulse |
| in_vld | input | 1 | Slice valid |
| in_u_sl | input | 2 | U slice |
| in_v_sl | input | 2 | V slice |
| interp_en | input | 1 | 1: filter, 0: copy through |
| film_sel | input | 1 | 1: four-tap set, 0: three-tap set |
| out_vld | output | 1 | Output sample valid |
| out_u | output | 8 | U output, two's complement |
| out_v | output | 8 | V output, two's complement |

## Verification
The checks assume several things about the inputs. Strobes are single-cycle and never share a cycle with a valid slice. No strobe comes in the first cycles after reset, while the internal reset is still being released. Each sample's four slices arrive back to back. The stimulus follows these rules throughout: every strobe is its own idle cycle, slices are driven in unbroken groups of four, and a field strobe always starts a filtered run. Expected values come from a bench-side history model that uses the coefficient tables stated above.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int CW       = 8;
  localparam int NTAP_MAX = 4;
  localparam int NTAP_CAM = 3;
  localparam int NPHASE   = 4;
  localparam int COEF_W   = 10;
  localparam int ACC_W    = 20;
  localparam int FRAC     = 7;

  localparam int CAM_DEF  [NPHASE*NTAP_CAM] = '{64, 64, 0, 32, 80, 16, 16, 80, 32, 0, 64, 64};
  localparam int FILM_DEF [NPHASE*NTAP_MAX] = '{-8, 72, 72, -8, -4, 48, 96, -12,
                                                -12, 96, 48, -4, 0, 128, 0, 0};

  typedef logic signed [CW-1:0] chroma_t;
  typedef struct packed {
    chroma_t u;
    chroma_t v;
  } uv_t;

  function automatic chroma_t round_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] r;
    r = (acc + ACC_W'(1 << (FRAC - 1))) >>> FRAC;
    if (r > ACC_W'(127)) return chroma_t'(127);
    else if (r < -ACC_W'(128)) return chroma_t'(-128);
    else return chroma_t'(r[CW-1:0]);
  endfunction
endpackage

// File: rtl/vcc_deslice.sv
module vcc_deslice
  import vcc_pkg::*;
#(
  parameter int LINE_SAMPLES = 16,
  localparam int CLW = $clog2(LINE_SAMPLES + 1)
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           restart,
  input  logic           in_vld,
  input  logic [1:0]     u_sl,
  input  logic [1:0]     v_sl,
  output logic           smp_done,
  output logic           col_ok,
  output logic [CLW-1:0] col,
  output uv_t            smp
);
  logic [1:0]     cnt_q, cnt_d;
  logic [5:0]     ush_q, ush_d, vsh_q, vsh_d;
  logic [CLW-1:0] col_q, col_d;
  logic           en;

  assign en = restart || in_vld;

  always_comb begin
    cnt_d = cnt_q;
    ush_d = ush_q;
    vsh_d = vsh_q;
    col_d = col_q;
    if (restart) begin
      cnt_d = '0;
      col_d = '0;
    end else if (in_vld) begin
      cnt_d = cnt_q + 2'd1;
      ush_d = {ush_q[3:0], u_sl};
      vsh_d = {vsh_q[3:0], v_sl};
      if (cnt_q == 2'd3 && col_q != CLW'(LINE_SAMPLES)) col_d = col_q + CLW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ush_q <= '0;
      vsh_q <= '0;
      col_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      ush_q <= ush_d;
      vsh_q <= vsh_d;
      col_q <= col_d;
    end
  end

  assign smp_done = in_vld && !restart && (cnt_q == 2'd3);
  assign col_ok   = (col_q < CLW'(LINE_SAMPLES));
  assign col      = col_q;
  assign smp.u    = chroma_t'({ush_q, u_sl});
  assign smp.v    = chroma_t'({vsh_q, v_sl});
endmodule

// File: rtl/vcc_phase_seq.sv
module vcc_phase_seq (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       fld_strb,
  input  logic       ln_strb,
  output logic [1:0] phase,
  output logic       push,
  output logic       flush
);
  logic [1:0] ph_q, ph_d;
  logic       en;

  assign en = fld_strb || ln_strb;

  always_comb begin
    ph_d = ph_q;
    if (fld_strb)     ph_d = 2'd0;
    else if (ln_strb) ph_d = ph_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  ph_q <= 2'd0;
    else if (en)  ph_q <= ph_d;
  end

  assign phase = ph_q;
  assign push  = ln_strb && !fld_strb && (ph_q != 2'd3);
  assign flush = fld_strb;
endmodule

// File: rtl/vcc_linestore.sv
module vcc_linestore
  import vcc_pkg::*;
#(
  parameter int LINE_SAMPLES = 16,
  localparam int CLW  = $clog2(LINE_SAMPLES + 1),
  localparam int IW   = $clog2(LINE_SAMPLES),
  localparam int PW   = $clog2(NTAP_MAX + 1),
  localparam int NBUF = 1 << PW,
  localparam int FW   = $clog2(NTAP_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                wr_en,
  input  logic [CLW-1:0]      col,
  input  uv_t                 wr_data,
  input  logic                push,
  input  logic                flush,
  output uv_t                 taps [NTAP_MAX],
  output logic [NTAP_MAX-1:0] tap_ok,
  output logic [PW-1:0]       wptr,
  output logic [FW-1:0]       fill
);
  uv_t           mem [NBUF][LINE_SAMPLES];
  logic [PW-1:0] wp_q, wp_d;
  logic [FW-1:0] fl_q, fl_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q][col[IW-1:0]] <= wr_data;
  end

  always_comb begin
    wp_d = wp_q;
    fl_d = fl_q;
    if (flush) begin
      fl_d = '0;
    end else if (push) begin
      wp_d = wp_q + PW'(1);
      if (fl_q != FW'(NTAP_MAX)) fl_d = fl_q + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      fl_q <= '0;
    end else if (flush || push) begin
      wp_q <= wp_d;
      fl_q <= fl_d;
    end
  end

  for (genvar k = 0; k < NTAP_MAX; k++) begin : g_tap
    logic [PW-1:0] slot;
    assign slot      = wp_q - PW'(k + 1);
    assign taps[k]   = mem[slot][col[IW-1:0]];
    assign tap_ok[k] = (fl_q > FW'(k));
  end

  assign wptr = wp_q;
  assign fill = fl_q;
endmodule

// File: rtl/vcc_vmac.sv
module vcc_vmac
  import vcc_pkg::*;
#(
  parameter int CAM_COEF  [NPHASE*NTAP_CAM] = CAM_DEF,
  parameter int FILM_COEF [NPHASE*NTAP_MAX] = FILM_DEF
) (
  input  logic                film_sel,
  input  logic [1:0]          phase,
  input  chroma_t             taps [NTAP_MAX],
  input  logic [NTAP_MAX-1:0] tap_ok,
  output chroma_t             y
);
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    logic signed [COEF_W-1:0]    coef;
    logic signed [COEF_W+CW-1:0] prod;
    acc = '0;
    for (int k = 0; k < NTAP_MAX; k++) begin
      coef = '0;
      if (film_sel)          coef = COEF_W'(FILM_COEF[int'(phase) * NTAP_MAX + k]);
      else if (k < NTAP_CAM) coef = COEF_W'(CAM_COEF[int'(phase) * NTAP_CAM + k]);
      prod = coef * taps[k];
      if (tap_ok[k]) acc = acc + ACC_W'(prod);
    end
  end

  assign y = round_sat(acc);
endmodule

// File: rtl/vcc_chroma_vsrc.sv
module vcc_chroma_vsrc
  import vcc_pkg::*;
#(
  parameter int LINE_SAMPLES = 16,
  parameter int CAM_COEF  [NPHASE*NTAP_CAM] = CAM_DEF,
  parameter int FILM_COEF [NPHASE*NTAP_MAX] = FILM_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fld_strb,
  input  logic       ln_strb,
  input  logic       in_vld,
  input  logic [1:0] in_u_sl,
  input  logic [1:0] in_v_sl,
  input  logic       interp_en,
  input  logic       film_sel,
  output logic       out_vld,
  output logic [7:0] out_u,
  output logic [7:0] out_v
);
  localparam int CLW = $clog2(LINE_SAMPLES + 1);
  localparam int PW  = $clog2(NTAP_MAX + 1);
  localparam int FW  = $clog2(NTAP_MAX + 1);

  logic [1:0]          rsync_q;
  logic                rst_ni;
  logic                smp_done, col_ok, push, flush;
  logic [CLW-1:0]      col;
  uv_t                 smp;
  logic [1:0]          phase;
  uv_t                 taps [NTAP_MAX];
  logic [NTAP_MAX-1:0] tap_ok;
  logic [PW-1:0]       wptr;
  logic [FW-1:0]       fill;
  chroma_t             filt [2];
  logic                ov_q, ov_d;
  chroma_t             ou_q, ou_d, ovv_q, ovv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  vcc_deslice #(.LINE_SAMPLES(LINE_SAMPLES)) u_deslice (
    .clk(clk), .rst_ni(rst_ni), .restart(fld_strb || ln_strb), .in_vld(in_vld),
    .u_sl(in_u_sl), .v_sl(in_v_sl), .smp_done(smp_done), .col_ok(col_ok),
    .col(col), .smp(smp));

  vcc_phase_seq u_seq (
    .clk(clk), .rst_ni(rst_ni), .fld_strb(fld_strb), .ln_strb(ln_strb),
    .phase(phase), .push(push), .flush(flush));

  vcc_linestore #(.LINE_SAMPLES(LINE_SAMPLES)) u_store (
    .clk(clk), .rst_ni(rst_ni), .wr_en(smp_done && col_ok), .col(col),
    .wr_data(smp), .push(push), .flush(flush), .taps(taps), .tap_ok(tap_ok),
    .wptr(wptr), .fill(fill));

  for (genvar g = 0; g < 2; g++) begin : g_comp
    chroma_t ctap [NTAP_MAX];
    for (genvar k = 0; k < NTAP_MAX; k++) begin : g_sel
      assign ctap[k] = (g == 0) ? taps[k].u : taps[k].v;
    end
    vcc_vmac #(.CAM_COEF(CAM_COEF), .FILM_COEF(FILM_COEF)) u_mac (
      .film_sel(film_sel), .phase(phase), .taps(ctap), .tap_ok(tap_ok), .y(filt[g]));
  end

  always_comb begin
    ov_d  = smp_done && col_ok;
    ou_d  = ou_q;
    ovv_d = ovv_q;
    if (ov_d) begin
      ou_d  = interp_en ? filt[0] : smp.u;
      ovv_d = interp_en ? filt[1] : smp.v;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q  <= 1'b0;
      ou_q  <= '0;
      ovv_q <= '0;
    end else begin
      ov_q <= ov_d;
      if (ov_d) begin
        ou_q  <= ou_d;
        ovv_q <= ovv_d;
      end
    end
  end

  assign out_vld = ov_q;
  assign out_u   = ou_q;
  assign out_v   = ovv_q;
endmodule

// File: rtl/vcc_chroma_vsrc_chk.sv
module vcc_chroma_vsrc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fld_strb,
  input logic       ln_strb,
  input logic       in_vld,
  input logic       interp_en,
  input logic       out_vld,
  input logic [7:0] out_u,
  input logic [7:0] out_v,
  input logic [1:0] phase,
  input logic [2:0] wptr,
  input logic [2:0] fill
);
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ln_strb && !fld_strb) |=> $stable(phase));

  assert_stall_keeps_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_strb && !fld_strb && phase == 2'd3) |=> $stable(wptr));

  assert_consume_moves_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_strb && !fld_strb && phase != 2'd3) |=> (wptr == 3'($past(wptr) + 3'd1)));

  assert_field_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fld_strb |=> (fill == 3'd0));

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 3'd4);

  assert_blank_without_history_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(interp_en) && $past(fill) == 3'd0) |-> (out_u == 8'd0 && out_v == 8'd0));

  assert_out_follows_slice_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));
endmodule

bind vcc_chroma_vsrc vcc_chroma_vsrc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fld_strb(fld_strb), .ln_strb(ln_strb), .in_vld(in_vld),
  .interp_en(interp_en), .out_vld(out_vld), .out_u(out_u), .out_v(out_v),
  .phase(phase), .wptr(wptr), .fill(fill));

// File: tb/vcc_chroma_vsrc_tb_top.sv
module vcc_chroma_vsrc_tb_top;
  localparam int LN = 16;
  localparam int CAMC  [12] = '{64, 64, 0, 32, 80, 16, 16, 80, 32, 0, 64, 64};
  localparam int FILMC [16] = '{-8, 72, 72, -8, -4, 48, 96, -12, -12, 96, 48, -4, 0, 128, 0, 0};
  // {u_in, v_in, u_exp, v_exp}; copy-through vectors, film_sel toggled per entry
  localparam logic [31:0] TBL [8] = '{
    32'h00_00_00_00, 32'h7F_80_7F_80, 32'hC3_3C_C3_3C, 32'h5A_A6_5A_A6,
    32'hFF_01_FF_01, 32'h81_7E_81_7E, 32'h12_ED_12_ED, 32'h96_69_96_69};

  logic       clk = 1'b0;
  logic       rst_n, fld_strb, ln_strb, in_vld, interp_en, film_sel;
  logic [1:0] in_u_sl, in_v_sl;
  logic       out_vld;
  logic [7:0] out_u, out_v;
  int checks = 0, fails = 0;
  int mfill, mph;
  logic signed [7:0] mh [4][LN][2];
  logic signed [7:0] cur [LN][2];

  always #5 clk = ~clk;

  vcc_chroma_vsrc dut_i (
    .clk(clk), .rst_n(rst_n), .fld_strb(fld_strb), .ln_strb(ln_strb), .in_vld(in_vld),
    .in_u_sl(in_u_sl), .in_v_sl(in_v_sl), .interp_en(interp_en), .film_sel(film_sel),
    .out_vld(out_vld), .out_u(out_u), .out_v(out_v));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [7:0] pat(int seed, int ln, int c, int comp);
    int x;
    x = (seed * 29 + ln * 37 + c * 11 + comp * 53) % 256;
    return 8'(x - 128);
  endfunction

  function automatic int model(int comp, int c, int inval);
    int acc, cf, r;
    if (!interp_en) return inval;
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      if (film_sel) cf = FILMC[mph * 4 + k];
      else          cf = (k < 3) ? CAMC[mph * 3 + k] : 0;
      if (k < mfill) acc += cf * int'(mh[k][c][comp]);
    end
    r = (acc + 64) >>> 7;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic send_sample(input logic [7:0] u, input logic [7:0] v, input int eu,
                             input int ev, input bit want, input string req);
    for (int s = 0; s < 4; s++) begin
      in_vld  = 1'b1;
      in_u_sl = u[7 - 2 * s -: 2];
      in_v_sl = v[7 - 2 * s -: 2];
      @(negedge clk);
    end
    in_vld = 1'b0;
    chk(out_vld == want, req, int'(out_vld), int'(want));
    if (want) begin
      chk($signed(out_u) == eu, req, $signed(out_u), eu);
      chk($signed(out_v) == ev, req, $signed(out_v), ev);
    end
  endtask

  // kind 0: pattern line; kind 1: constant line (cu, cv)
  task automatic run_line(input int seed, input int lid, input int kind, input int cu,
                          input int cv, input string req);
    logic signed [7:0] u, v;
    for (int c = 0; c < LN; c++) begin
      u = (kind == 1) ? 8'(cu) : pat(seed, lid, c, 0);
      v = (kind == 1) ? 8'(cv) : pat(seed, lid, c, 1);
      cur[c][0] = u;
      cur[c][1] = v;
      send_sample(u, v, model(0, c, int'(u)), model(1, c, int'(v)), 1'b1, req);
    end
  endtask

  task automatic strobe_line();
    ln_strb = 1'b1;
    @(negedge clk);
    ln_strb = 1'b0;
    if (mph != 3) begin
      for (int k = 3; k > 0; k--)
        for (int c = 0; c < LN; c++) begin
          mh[k][c][0] = mh[k-1][c][0];
          mh[k][c][1] = mh[k-1][c][1];
        end
      for (int c = 0; c < LN; c++) begin
        mh[0][c][0] = cur[c][0];
        mh[0][c][1] = cur[c][1];
      end
      if (mfill < 4) mfill++;
    end
    mph = (mph + 1) % 4;
  endtask

  task automatic strobe_field();
    fld_strb = 1'b1;
    @(negedge clk);
    fld_strb = 1'b0;
    mfill = 0;
    mph   = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fld_strb = 1'b0; ln_strb = 1'b0; in_vld = 1'b0;
    in_u_sl = '0; in_v_sl = '0; interp_en = 1'b0; film_sel = 1'b0;
    mfill = 0; mph = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(out_vld == 1'b0, "R10 reset out_vld", int'(out_vld), 0);
    chk(out_u == 8'd0 && out_v == 8'd0, "R10 reset data", int'(out_u), 0);

    // R1 / R2: table walk in copy-through mode, film_sel must not matter
    for (int i = 0; i < 8; i++) begin
      film_sel = i[0];
      send_sample(TBL[i][31:24], TBL[i][23:16], int'($signed(TBL[i][15:8])),
                  int'($signed(TBL[i][7:0])), 1'b1, "R1 R2 table");
    end

    // R9: extra samples beyond the line length give nothing
    film_sel = 1'b0;
    strobe_line();
    for (int c = 0; c < LN + 2; c++)
      send_sample(8'(c * 7), 8'(c * 3), int'($signed(8'(c * 7))), int'($signed(8'(c * 3))),
                  c < LN, "R9 line length");

    // R3 R4 R5 R8: camera field, first line blank, stall lines discarded
    interp_en = 1'b1;
    film_sel  = 1'b0;
    strobe_field();
    for (int l = 0; l < 10; l++) begin
      run_line(3, l, 0, 0, 0, (l == 0) ? "R8 first line" : "R5 R3 R4 camera");
      strobe_line();
    end

    // R6: film field
    film_sel = 1'b1;
    strobe_field();
    for (int l = 0; l < 10; l++) begin
      run_line(11, l, 0, 0, 0, "R6 R4 film");
      strobe_line();
    end

    // R7: saturation; lines a=b=127,c=-128 for U, opposite for V, then stall, then phase 0
    strobe_field();
    run_line(0, 0, 1, 127, -128, "R7 fill");   strobe_line();
    run_line(0, 1, 1, 127, -128, "R7 fill");   strobe_line();
    run_line(0, 2, 1, -128, 127, "R7 fill");   strobe_line();
    run_line(0, 3, 1, 99, 99, "R4 stall line"); strobe_line();
    // phase 0 with history [-128,127,127]: U clamps to 127, V clamps to -128
    send_sample(8'd5, 8'd5, 127, -128, 1'b1, "R7 clamp");

    // R8: a new field drops previous history in camera mode
    film_sel = 1'b0;
    strobe_field();
    send_sample(8'd77, 8'd88, 0, 0, 1'b1, "R8 field restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule